// File: doc/BRIEF.md
# CAN / CAN-FD Bit Destuffer

This block sits between the bit sampler and the frame decoder of a CAN receiver. Each sampled bus bit arrives with a one-cycle strobe. The block decides whether that bit is a dynamic stuff bit or a real frame bit. Frame bits are forwarded with their position in the destuffed frame. Stuff bits are flagged and then dropped. A raw bit counter runs alongside, so the sampler can keep its bit grid aligned, stuff bits included.

The frame decoder controls the block through four inputs. A frame-reset clears the block between frames. An FD flag selects the flexible-data-rate rules. A last-data-index value, with its own valid bit, tells the block where the data field ends. Once the frame passes the configured end of the dynamic-stuffing region, runs are no longer treated as stuff. That end is the last data bit in FD frames and seventeen bits beyond it in classic frames. Until the decoder marks the index valid, the region is unbounded. Checking the fixed stuff bits of the FD CRC field is left to the frame decoder.

Top module: `can_destuffer`

## Requirements
- R1: A raw bit is a stuff bit when the five raw bits before it, all since the last frame reset, share one value and the current bit has the opposite value. With fewer than five earlier raw bits in the frame, no bit is a stuff bit.
- R2: A frame bit gives a one-cycle `frm_valid` pulse carrying its value and its destuffed index. Indexes count 0, 1, 2 and so on from the frame reset. A stuff bit gives a one-cycle `stuff_seen` pulse instead, and the index does not advance.
- R3: Stuff bits remain in the run history. A run that contains a stuff bit can therefore cause the next stuff decision.
- R4: With `fd_mode`=1 and `last_idx_vld`=1, no bit is a stuff bit once the number of frame bits already delivered is at least `last_idx`.
- R5: With `fd_mode`=0 and `last_idx_vld`=1, no bit is a stuff bit once the number of frame bits already delivered is at least `last_idx`+17.
- R6: While `last_idx_vld`=0, the region limit is unbounded and the value on `last_idx` has no effect, in either mode.
- R7: `raw_cnt` counts every accepted raw bit since the frame reset, stuff bits included.
- R8: `frame_rst` clears the history, both counters and the output pulses. A raw bit strobed in the same cycle as `frame_rst` is discarded.
- R9: After `rst`, all outputs are zero. The result for a bit strobed at one clock edge appears at the next edge and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_rst | input | 1 | Synchronous start-of-frame clear from the frame decoder |
| raw_valid | input | 1 | Strobe: `raw_bit` holds a new sampled bit |
| raw_bit | input | 1 | Sampled bus level (0 dominant, 1 recessive) |
| fd_mode | input | 1 | 1 selects the FD stuffing region, 0 the classic one |
| last_idx_vld | input | 1 | `last_idx` is known |
| last_idx | input | IDX_W | Destuffed index of the last data bit |
| frm_valid | output | 1 | One-cycle pulse: a frame bit is delivered |
| frm_bit | output | 1 | Value of the delivered frame bit |
| frm_idx | output | IDX_W | Destuffed index of the delivered frame bit |
| stuff_seen | output | 1 | One-cycle pulse: the last raw bit was removed as stuff |
| raw_cnt | output | RAW_W | Raw bits accepted since the frame reset |

## Verification
A corrupted run history shows up on the very next bit that completes or breaks a run. A bit that should be stuff arrives as a frame bit, or the reverse, and every later `frm_idx` in the frame is then shifted by one. An off-by-one in the region limit is only visible at its boundary, so each mode is driven with limit values exactly on and just past the bit that would close a run. A missing fill guard shows up on a frame's first few bits because the cleared history looks like a run of zeros.

// File: rtl/can_destuff_pkg.sv
package can_destuff_pkg;

    localparam int IDX_W_DEF    = 10;
    localparam int RAW_W_DEF    = 11;
    localparam int RUN_LEN_DEF  = 5;
    localparam int CLASSIC_TAIL = 17;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_FRAME = 2'd1,
        BK_STUFF = 2'd2
    } bit_kind_e;

    function automatic bit_kind_e classify(input logic strobe, input logic is_stuff);
        if (!strobe)
            return BK_IDLE;
        else if (is_stuff)
            return BK_STUFF;
        else
            return BK_FRAME;
    endfunction

endpackage

// File: rtl/can_destuff_hist.sv
module can_destuff_hist #(
    parameter int RUN_LEN = can_destuff_pkg::RUN_LEN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic shift,
    input  logic bit_in,
    output logic stuff_hit
);
    localparam int FW = $clog2(RUN_LEN + 1);
    localparam logic [FW-1:0] FULL = FW'(RUN_LEN);

    logic [RUN_LEN-1:0] hist;
    logic [FW-1:0]      fill;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist <= '0;
            fill <= '0;
        end else if (shift) begin
            hist <= {hist[RUN_LEN-2:0], bit_in};
            if (fill != FULL)
                fill <= fill + 1'b1;
        end
    end

    always_comb begin
        stuff_hit = (fill == FULL) &&
                    (((&hist) && !bit_in) || ((~|hist) && bit_in));
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL); // R1

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> !stuff_hit); // R8

endmodule

// File: rtl/can_destuff_window.sv
module can_destuff_window #(
    parameter int IDX_W = can_destuff_pkg::IDX_W_DEF,
    parameter int TAIL  = can_destuff_pkg::CLASSIC_TAIL
) (
    input  logic             fd_mode,
    input  logic             last_vld,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [IDX_W-1:0] done_cnt,
    output logic             dyn_en
);
    localparam logic [IDX_W:0] TAIL_X = (IDX_W + 1)'(TAIL);

    logic [IDX_W:0] limit;

    always_comb begin
        limit  = fd_mode ? {1'b0, last_idx} : ({1'b0, last_idx} + TAIL_X);
        dyn_en = !last_vld || ({1'b0, done_cnt} < limit);
    end

endmodule

// File: rtl/can_destuffer.sv
module can_destuffer
    import can_destuff_pkg::*;
#(
    parameter int IDX_W   = IDX_W_DEF,
    parameter int RAW_W   = RAW_W_DEF,
    parameter int RUN_LEN = RUN_LEN_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_rst,
    input  logic             raw_valid,
    input  logic             raw_bit,
    input  logic             fd_mode,
    input  logic             last_idx_vld,
    input  logic [IDX_W-1:0] last_idx,
    output logic             frm_valid,
    output logic             frm_bit,
    output logic [IDX_W-1:0] frm_idx,
    output logic             stuff_seen,
    output logic [RAW_W-1:0] raw_cnt
);
    localparam logic [IDX_W:0]   TAIL_X  = (IDX_W + 1)'(CLASSIC_TAIL);
    localparam logic [RAW_W-1:0] MIN_RAW = RAW_W'(RUN_LEN + 1);

    logic             accept;
    logic             stuff_hit;
    logic             dyn_en;
    logic [IDX_W-1:0] done_cnt;
    bit_kind_e        kind;

    assign accept = raw_valid && !frame_rst;

    can_destuff_hist #(.RUN_LEN(RUN_LEN)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .clr       (frame_rst),
        .shift     (accept),
        .bit_in    (raw_bit),
        .stuff_hit (stuff_hit)
    );

    can_destuff_window #(.IDX_W(IDX_W), .TAIL(CLASSIC_TAIL)) u_window (
        .fd_mode  (fd_mode),
        .last_vld (last_idx_vld),
        .last_idx (last_idx),
        .done_cnt (done_cnt),
        .dyn_en   (dyn_en)
    );

    always_comb begin
        kind = classify(accept, stuff_hit && dyn_en);
    end

    always_ff @(posedge clk) begin
        if (rst || frame_rst) begin
            frm_valid  <= 1'b0;
            frm_bit    <= 1'b0;
            frm_idx    <= '0;
            stuff_seen <= 1'b0;
            raw_cnt    <= '0;
            done_cnt   <= '0;
        end else begin
            frm_valid  <= 1'b0;
            stuff_seen <= 1'b0;
            case (kind)
                BK_FRAME: begin
                    frm_valid <= 1'b1;
                    frm_bit   <= raw_bit;
                    frm_idx   <= done_cnt;
                    done_cnt  <= done_cnt + 1'b1;
                    raw_cnt   <= raw_cnt + 1'b1;
                end
                BK_STUFF: begin
                    stuff_seen <= 1'b1;
                    raw_cnt    <= raw_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        !(frm_valid && stuff_seen)); // R2

    AST_BIT_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        (raw_valid && !frame_rst) |=> (frm_valid || stuff_seen)); // R9

    AST_STUFF_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
        stuff_seen |-> (raw_cnt >= MIN_RAW)); // R1

    AST_FD_REGION: assert property (@(posedge clk) disable iff (rst)
        (raw_valid && fd_mode && last_idx_vld && (done_cnt >= last_idx))
        |=> !stuff_seen); // R4

    AST_CLASSIC_REGION: assert property (@(posedge clk) disable iff (rst)
        (raw_valid && !fd_mode && last_idx_vld &&
         ({1'b0, done_cnt} >= ({1'b0, last_idx} + TAIL_X)))
        |=> !stuff_seen); // R5

    AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (rst)
        frame_rst |=> (!frm_valid && !stuff_seen && (raw_cnt == '0))); // R8

endmodule

// File: tb/can_destuffer_test.sv
module can_destuffer_test;
    localparam int IDX_W = 10;
    localparam int RAW_W = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             frame_rst = 1'b0;
    logic             raw_valid = 1'b0;
    logic             raw_bit = 1'b0;
    logic             fd_mode = 1'b0;
    logic             last_idx_vld = 1'b0;
    logic [IDX_W-1:0] last_idx = '0;
    logic             frm_valid;
    logic             frm_bit;
    logic [IDX_W-1:0] frm_idx;
    logic             stuff_seen;
    logic [RAW_W-1:0] raw_cnt;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    can_destuffer #(.IDX_W(IDX_W), .RAW_W(RAW_W), .RUN_LEN(5)) uut (
        .clk(clk), .rst(rst), .frame_rst(frame_rst), .raw_valid(raw_valid),
        .raw_bit(raw_bit), .fd_mode(fd_mode), .last_idx_vld(last_idx_vld),
        .last_idx(last_idx), .frm_valid(frm_valid), .frm_bit(frm_bit),
        .frm_idx(frm_idx), .stuff_seen(stuff_seen), .raw_cnt(raw_cnt)
    );

    // Row: {raw bit, expect stuff, expected index}; classic mode, limit unknown.
    localparam logic [6:0] VEC [20] = '{
        {1'b0, 1'b0, 5'd0},  {1'b0, 1'b0, 5'd1},  {1'b0, 1'b0, 5'd2},
        {1'b0, 1'b0, 5'd3},  {1'b0, 1'b0, 5'd4},  {1'b1, 1'b1, 5'd0},
        {1'b1, 1'b0, 5'd5},  {1'b1, 1'b0, 5'd6},  {1'b1, 1'b0, 5'd7},
        {1'b1, 1'b0, 5'd8},  {1'b0, 1'b1, 5'd0},  {1'b0, 1'b0, 5'd9},
        {1'b0, 1'b0, 5'd10}, {1'b0, 1'b0, 5'd11}, {1'b0, 1'b0, 5'd12},
        {1'b0, 1'b0, 5'd13}, {1'b1, 1'b1, 5'd0},  {1'b0, 1'b0, 5'd14},
        {1'b1, 1'b0, 5'd15}, {1'b0, 1'b0, 5'd16}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic b);
        @(negedge clk);
        raw_valid = 1'b1;
        raw_bit   = b;
        @(negedge clk);
        raw_valid = 1'b0;
    endtask

    task automatic new_frame();
        @(negedge clk);
        frame_rst = 1'b1;
        @(negedge clk);
        frame_rst = 1'b0;
    endtask

    task automatic expect_frame(input string req, input int idx, input logic b);
        check({req, " frm_valid"}, int'(frm_valid), 1);
        check({req, " stuff_seen"}, int'(stuff_seen), 0);
        check({req, " frm_idx"}, int'(frm_idx), idx);
        check({req, " frm_bit"}, int'(frm_bit), int'(b));
    endtask

    task automatic expect_stuff(input string req);
        check({req, " stuff_seen"}, int'(stuff_seen), 1);
        check({req, " frm_valid"}, int'(frm_valid), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 reset frm_valid", int'(frm_valid), 0);
        check("R9 reset stuff_seen", int'(stuff_seen), 0);
        check("R9 reset raw_cnt", int'(raw_cnt), 0);

        // Table walk: R1 R2 R3 in classic mode, limit unknown
        new_frame();
        for (int i = 0; i < 20; i++) begin
            send(VEC[i][6]);
            if (VEC[i][5])
                expect_stuff($sformatf("R2/R3 vec%0d", i));
            else
                expect_frame($sformatf("R1/R2 vec%0d", i), int'(VEC[i][4:0]), VEC[i][6]);
        end
        check("R7 raw_cnt after table", int'(raw_cnt), 20);
        @(negedge clk);
        check("R9 pulse is one cycle", int'(frm_valid), 0);

        // R1 fill guard: first bit 1, then 0000 then 1
        new_frame();
        send(1'b1);
        expect_frame("R1 first bit", 0, 1'b1);
        new_frame();
        for (int i = 0; i < 4; i++) send(1'b0);
        send(1'b1);
        expect_frame("R1 four prior bits", 4, 1'b1);

        // R4 FD region boundary
        fd_mode = 1'b1; last_idx_vld = 1'b1; last_idx = 10'd5;
        new_frame();
        for (int i = 0; i < 5; i++) send(1'b0);
        send(1'b1);
        expect_frame("R4 fd at limit", 5, 1'b1);
        last_idx = 10'd6;
        new_frame();
        for (int i = 0; i < 5; i++) send(1'b0);
        send(1'b1);
        expect_stuff("R4 fd before limit");

        // R6 limit unknown, index input ignored
        last_idx_vld = 1'b0; last_idx = 10'd0;
        new_frame();
        for (int i = 0; i < 5; i++) send(1'b0);
        send(1'b1);
        expect_stuff("R6 fd unbounded");

        // R5 classic region boundary
        fd_mode = 1'b0; last_idx_vld = 1'b1;
        for (int lim = 0; lim < 2; lim++) begin
            last_idx = IDX_W'(lim);
            new_frame();
            for (int i = 0; i < 12; i++) send(logic'(i % 2));
            for (int i = 0; i < 5; i++) send(1'b0);
            send(1'b1);
            if (lim == 0)
                expect_frame("R5 classic at limit", 17, 1'b1);
            else
                expect_stuff("R5 classic before limit");
            check("R7 raw_cnt classic", int'(raw_cnt), 18);
        end

        // R8 frame reset mid-frame and simultaneous strobe
        last_idx_vld = 1'b0;
        new_frame();
        send(1'b0); send(1'b0); send(1'b0);
        @(negedge clk);
        frame_rst = 1'b1; raw_valid = 1'b1; raw_bit = 1'b1;
        @(negedge clk);
        frame_rst = 1'b0; raw_valid = 1'b0;
        check("R8 cleared raw_cnt", int'(raw_cnt), 0);
        check("R8 no pulse", int'(frm_valid), 0);
        send(1'b0); send(1'b0);
        expect_frame("R8 index restarts", 1, 1'b0);
        check("R8 dropped bit not counted", int'(raw_cnt), 2);

        finish_run();
    end
endmodule